// File: doc/BRIEF.md
# L2 MAC/VLAN Bucket Hash Generator

This block turns a forwarding lookup key, a 48-bit station address and a 12-bit VLAN identifier, into an 11-bit bucket number for the layer-2 forwarding hash table. It joins the two fields into one 60-bit seed, with the address in the upper bits and the VLAN identifier below it. It then cuts the seed into 11-bit slices and folds them together with XOR.

Two folding algorithms are supported, and a mode input chooses between them for each request. The plain fold XORs the slices unchanged. The rotated fold first rotates three of the slices by different amounts, which spreads clustered addresses across more buckets. The lookup pipeline presents one key per cycle with a valid strobe. The bucket number appears one cycle later on a registered output. Choosing a slot inside the bucket and reading the table are left to neighbouring logic.

Top module: `l2_bucket_hash`

## Requirements
- R1: The seed is `{req_mac, req_vid}` (60 bits). Slice k (k = 0..5) is seed bits [11k+10 : 11k]. Seed bits above 59 read as zero, so slice 5 holds only seed bits 59..55 in its low five bits.
- R2: With `rotate_mode` = 0, the bucket number is the XOR of all six slices, none of them rotated.
- R3: With `rotate_mode` = 1, three slices are rotated before the XOR. Slice 1 becomes `{s[4:0], s[10:5]}`. Slice 3 becomes `{s[5:0], s[10:6]}`. Slice 4 becomes `{s[6:0], s[10:7]}`.
- R4: With `rotate_mode` = 1, slices 0, 2 and 5 enter the XOR unrotated.
- R5: `rotate_mode` is sampled together with `req_valid` and applies to that request only, so the mode may change from one cycle to the next.
- R6: `hash_valid` equals `req_valid` delayed by one clock. `hash_index` then holds the bucket number of the key presented in that earlier cycle.
- R7: In a cycle with `req_valid` = 0, the key and mode inputs are ignored, and `hash_index` keeps its previous value.
- R8: A clock edge with `rst_n` low sets `hash_valid` to 0 and `hash_index` to 0, whatever `req_valid` is.
- R9: Requests on consecutive cycles are each hashed, with no bubble between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Key on the request inputs is valid this cycle |
| req_mac | input | 48 | Station address of the key |
| req_vid | input | 12 | VLAN identifier of the key |
| rotate_mode | input | 1 | 1 selects the rotated fold, 0 the plain fold |
| hash_valid | output | 1 | Bucket number on `hash_index` is fresh |
| hash_index | output | 11 | Bucket number |

## Verification
The bench builds the block with its default widths: a 48-bit address, a 12-bit VLAN identifier and an 11-bit bucket. With these widths the slice edges fall at the offsets given in R1, and a single set address bit can be walked into each slice in turn. Each one-hot key lands on one known output bit in each mode, so every rotation and the truncated top slice can be told apart. A reference fold, written from the requirements, then checks a long pseudo-random stream with mixed modes and back-to-back requests.

// File: rtl/l2hash_pkg.sv
// Package l2hash_pkg
// Shared widths and the per-slice rotation table for the bucket hash.
// Assumes slice indices are small integers (0..NSLICE-1).
package l2hash_pkg;

    localparam int DEF_MAC_W = 48;
    localparam int DEF_VID_W = 12;
    localparam int DEF_IDX_W = 11;

    // Number of low slice bits moved to the top in rotated mode; 0 = no rotation.
    function automatic int rot_low_bits(input int slice_no);
        case (slice_no)
            1:       return 5;
            3:       return 6;
            4:       return 7;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/l2hash_seed.sv
// Module l2hash_seed
// Joins address and VLAN identifier into the seed and pads it with zeros
// up to a whole number of slices. Purely combinational.
module l2hash_seed #(
    parameter int MAC_W = 48,
    parameter int VID_W = 12,
    parameter int PAD_W = 66
) (
    input  logic [MAC_W-1:0] mac,
    input  logic [VID_W-1:0] vid,
    output logic [PAD_W-1:0] seed_pad
);

    localparam int SEED_W = MAC_W + VID_W;

    // Choose padded or exact-fit seed layout.
    generate
        if (PAD_W > SEED_W) begin : g_pad
            assign seed_pad = {{(PAD_W - SEED_W){1'b0}}, mac, vid};
        end else begin : g_exact
            assign seed_pad = {mac, vid};
        end
    endgenerate

endmodule

// File: rtl/l2hash_slice.sv
// Module l2hash_slice
// Passes one seed slice through, or rotates it so that its LOW_N low bits
// move to the top, when rot_en is set. LOW_N = 0 builds a plain wire.
module l2hash_slice #(
    parameter int IDX_W = 11,
    parameter int LOW_N = 0
) (
    input  logic [IDX_W-1:0] raw,
    input  logic             rot_en,
    output logic [IDX_W-1:0] sliced
);

    // Pick the structure from the rotation amount.
    generate
        if (LOW_N > 0 && LOW_N < IDX_W) begin : g_rot
            logic [IDX_W-1:0] rotated;
            assign rotated = {raw[LOW_N-1:0], raw[IDX_W-1:LOW_N]};
            assign sliced  = rot_en ? rotated : raw;
        end else begin : g_plain
            logic unused_en;
            assign unused_en = rot_en;
            assign sliced    = raw;
        end
    endgenerate

endmodule

// File: rtl/l2hash_fold.sv
// Module l2hash_fold
// XOR-reduces NSLICE prepared slices into one bucket number.
module l2hash_fold #(
    parameter int IDX_W  = 11,
    parameter int NSLICE = 6
) (
    input  logic [NSLICE-1:0][IDX_W-1:0] slices,
    output logic [IDX_W-1:0]             folded
);

    // XOR every slice into the result.
    always_comb begin
        folded = '0;
        for (int k = 0; k < NSLICE; k++) begin
            folded = folded ^ slices[k];
        end
    end

endmodule

// File: rtl/l2_bucket_hash.sv
// Module l2_bucket_hash
// Hashes {mac, vid} into a bucket number with a plain or rotated XOR fold,
// registered once. Assumes a synchronous active-low reset, and that the key
// is only meaningful while req_valid is high.
module l2_bucket_hash #(
    parameter int MAC_W = l2hash_pkg::DEF_MAC_W,
    parameter int VID_W = l2hash_pkg::DEF_VID_W,
    parameter int IDX_W = l2hash_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [MAC_W-1:0] req_mac,
    input  logic [VID_W-1:0] req_vid,
    input  logic             rotate_mode,
    output logic             hash_valid,
    output logic [IDX_W-1:0] hash_index
);

    localparam int SEED_W = MAC_W + VID_W;
    localparam int NSLICE = (SEED_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NSLICE * IDX_W;

    logic [PAD_W-1:0]             seed_pad;
    logic [NSLICE-1:0][IDX_W-1:0] prepared;
    logic [IDX_W-1:0]             folded;

    l2hash_seed #(
        .MAC_W (MAC_W),
        .VID_W (VID_W),
        .PAD_W (PAD_W)
    ) seed_i (
        .mac      (req_mac),
        .vid      (req_vid),
        .seed_pad (seed_pad)
    );

    // One slice unit per seed slice, each with its own rotation amount.
    generate
        for (genvar k = 0; k < NSLICE; k++) begin : g_slice
            l2hash_slice #(
                .IDX_W (IDX_W),
                .LOW_N (l2hash_pkg::rot_low_bits(k))
            ) slice_i (
                .raw    (seed_pad[k*IDX_W +: IDX_W]),
                .rot_en (rotate_mode),
                .sliced (prepared[k])
            );
        end
    endgenerate

    l2hash_fold #(
        .IDX_W  (IDX_W),
        .NSLICE (NSLICE)
    ) fold_i (
        .slices (prepared),
        .folded (folded)
    );

    // Output register: valid follows the strobe, index loads only on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_valid <= 1'b0;
            hash_index <= '0;
        end else begin
            hash_valid <= req_valid;
            if (req_valid) begin
                hash_index <= folded;
            end
        end
    end

endmodule

// File: rtl/l2_bucket_hash_chk.sv
// Module l2_bucket_hash_chk
// Temporal checks on the bucket hash ports; bound into every instance.
module l2_bucket_hash_chk #(
    parameter int MAC_W = 48,
    parameter int VID_W = 12,
    parameter int IDX_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [MAC_W-1:0] req_mac,
    input logic [VID_W-1:0] req_vid,
    input logic             rotate_mode,
    input logic             hash_valid,
    input logic [IDX_W-1:0] hash_index
);

    localparam int VIDBIT_POS = IDX_W - l2hash_pkg::rot_low_bits(1);

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (hash_valid == $past(req_valid)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid) |=> $stable(hash_index));

    assert_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!hash_valid && hash_index == '0));

    // With a zero address only the VLAN field feeds slices 0 and 1 (R2).
    assert_vid_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mac == '0 && !rotate_mode) |=>
        (hash_index == ($past(req_vid[IDX_W-1:0]) ^ IDX_W'($past(req_vid) >> IDX_W))));

    // Rotated mode moves the top VLAN bit from slice-1 bit 0 upward (R3).
    assert_vid_rot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mac == '0 && rotate_mode) |=>
        (hash_index == ($past(req_vid[IDX_W-1:0]) ^
                        (IDX_W'($past(req_vid) >> IDX_W) << VIDBIT_POS))));

endmodule

bind l2_bucket_hash l2_bucket_hash_chk #(
    .MAC_W (MAC_W),
    .VID_W (VID_W),
    .IDX_W (IDX_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_mac     (req_mac),
    .req_vid     (req_vid),
    .rotate_mode (rotate_mode),
    .hash_valid  (hash_valid),
    .hash_index  (hash_index)
);

// File: tb/l2_bucket_hash_tb_top.sv
// Bench for l2_bucket_hash: a vector table, then directed reset, hold,
// back-to-back and pseudo-random checks against a reference fold.
module l2_bucket_hash_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_mac = '0;
    logic [11:0] req_vid = '0;
    logic        rotate_mode = 1'b0;
    logic        hash_valid;
    logic [10:0] hash_index;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    l2_bucket_hash dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_mac     (req_mac),
        .req_vid     (req_vid),
        .rotate_mode (rotate_mode),
        .hash_valid  (hash_valid),
        .hash_index  (hash_index)
    );

    typedef struct packed {
        logic [47:0] mac;
        logic [11:0] vid;
        logic        mode;
        logic [10:0] exp;
    } vec_t;

    // One-hot keys walked through each slice, with hand-derived results.
    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{48'h0,              12'h000, 1'b0, 11'h000},
        '{48'h0,              12'hFFF, 1'b0, 11'h7FE},
        '{48'h0,              12'hFFF, 1'b1, 11'h7BF},
        '{48'h8000_0000_0000, 12'h000, 1'b0, 11'h010},
        '{48'h8000_0000_0000, 12'h000, 1'b1, 11'h010},
        '{48'h0000_0000_0001, 12'h000, 1'b0, 11'h002},
        '{48'h0000_0000_0001, 12'h000, 1'b1, 11'h080},
        '{48'h0000_0020_0000, 12'h000, 1'b0, 11'h001},
        '{48'h0000_0020_0000, 12'h000, 1'b1, 11'h020},
        '{48'h0001_0000_0000, 12'h000, 1'b0, 11'h001},
        '{48'h0001_0000_0000, 12'h000, 1'b1, 11'h010},
        '{48'h0000_8000_0000, 12'h000, 1'b1, 11'h010},
        '{48'h0000_0000_0400, 12'h000, 1'b1, 11'h001},
        '{48'h0000_0000_0200, 12'h000, 1'b0, 11'h400},
        '{48'h0000_0000_0200, 12'h000, 1'b1, 11'h020},
        '{48'h0400_0000_0000, 12'h000, 1'b1, 11'h008}
    };

    // Reference fold written from the requirements with integer shifts.
    function automatic logic [10:0] ref_hash(logic [47:0] m, logic [11:0] v, logic mode);
        logic [63:0] s;
        logic [10:0] a1, a3, a4, h;
        s  = {4'b0, m, v};
        a1 = 11'((s >> 11) & 64'h7FF);
        a3 = 11'((s >> 33) & 64'h7FF);
        a4 = 11'((s >> 44) & 64'h7FF);
        if (mode) begin
            a1 = 11'(((a1 & 11'h1F) << 6) | (a1 >> 5));
            a3 = 11'(((a3 & 11'h3F) << 5) | (a3 >> 6));
            a4 = 11'(((a4 & 11'h7F) << 4) | (a4 >> 7));
        end
        h = 11'(s & 64'h7FF) ^ a1 ^ 11'((s >> 22) & 64'h7FF) ^ a3 ^ a4
            ^ 11'((s >> 55) & 64'h1FF);
        return h;
    endfunction

    task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [47:0] m, input logic [11:0] d, input logic md);
        req_valid   = v;
        req_mac     = m;
        req_vid     = d;
        rotate_mode = md;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [63:0] lfsr;
        logic [10:0] prev_exp;
        logic [10:0] held;
        lfsr = 64'h1234_5678_9ABC_DEF1;

        // R8: reset state, with a valid request pending during reset.
        drive(1'b1, 48'hFFFF_FFFF_FFFF, 12'hFFF, 1'b1);
        repeat (3) @(negedge clk);
        chk("R8 valid in reset", 11'(hash_valid), 11'd0);
        chk("R8 index in reset", hash_index, 11'd0);
        drive(1'b0, '0, '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 valid after reset", 11'(hash_valid), 11'd0);

        // R1 R2 R3 R4: vector table, one request per entry.
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VECS[i].mac, VECS[i].vid, VECS[i].mode);
            @(negedge clk);
            drive(1'b0, '0, '0, 1'b0);
            chk(VECS[i].mode ? "R3 R4 R1 table rotated" : "R2 R1 table plain",
                hash_index, VECS[i].exp);
            chk("R6 valid one cycle later", 11'(hash_valid), 11'd1);
            @(negedge clk);
            chk("R6 valid drops", 11'(hash_valid), 11'd0);
        end

        // R7: inputs change while req_valid is low; index must hold.
        drive(1'b1, 48'h0000_0000_0001, 12'h000, 1'b1);
        @(negedge clk);
        held = hash_index;
        chk("R7 setup", held, 11'h080);
        drive(1'b0, 48'hA5A5_5A5A_F0F0, 12'h3C3, 1'b0);
        @(negedge clk);
        chk("R7 index held", hash_index, held);
        drive(1'b0, 48'h0F0F_1234_8888, 12'h777, 1'b1);
        @(negedge clk);
        chk("R7 index held again", hash_index, held);
        chk("R7 valid low", 11'(hash_valid), 11'd0);

        // R5 R9: back-to-back requests with the mode toggling every cycle.
        prev_exp = '0;
        for (int i = 0; i < 200; i++) begin
            logic [47:0] m;
            logic [11:0] d;
            logic        md;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            m  = lfsr[63:16];
            d  = lfsr[11:0];
            md = i[0];
            drive(1'b1, m, d, md);
            @(negedge clk);
            chk(md ? "R9 R5 R3 stream rotated" : "R9 R5 R2 stream plain",
                hash_index, ref_hash(m, d, md));
            chk("R9 valid stays high", 11'(hash_valid), 11'd1);
            prev_exp = hash_index;
        end

        // R8: reset mid-stream clears outputs even with valid high.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 index cleared", hash_index, 11'd0);
        chk("R8 valid cleared", 11'(hash_valid), 11'd0);
        rst_n = 1'b1;
        drive(1'b0, '0, '0, 1'b0);
        @(negedge clk);
        chk("R7 R8 idle after reset", hash_index, 11'd0);

        done = 1'b1;
        finish_run();
    end

endmodule